// File: doc/BRIEF.md
# Upward-Growing Stack Pointer Unit

This block holds a 16-bit stack pointer and drives its own word-addressed stack memory port, 16 bits per beat. The stack grows toward higher addresses, and the pointer always names the next free word. A caller issues one of five operations. There are 16-bit and 32-bit pushes, 16-bit and 32-bit pops, and a signed 8-bit add to the pointer. A one-cycle `done` pulse reports that an operation has finished.

A 32-bit transfer is split into two sequential bus beats. The pointer is never forced to any alignment. Instead, the memory-side address of a 32-bit transfer has its bit 0 cleared. The low half always goes to (or comes from) the even word, and the high half uses the odd word above it. All pointer arithmetic wraps modulo 2^16. The 32-bit bus address carries the pointer in its low half, and the upper half is always zero. A small internal RAM model stands in for the stack memory. It aliases addresses onto its depth.

Top module: `sp_stack_unit`

## Requirements
- R1: After reset the pointer reads 0x0400, and `busy`, `done` and `bus_en` are low.
- R2: Op code 0 (16-bit push) writes `req_wdata[15:0]` to the word at the current pointer in one beat, and the pointer becomes pointer+1. `done` is seen two cycles after the accepting edge.
- R3: Op code 1 (32-bit push) writes `req_wdata[15:0]` to the even address A = pointer with bit 0 cleared, then writes `req_wdata[31:16]` to A+1 in the next beat. The pointer becomes pointer+2, and `done` is seen three cycles after acceptance.
- R4: Op code 2 (16-bit pop) first lowers the pointer by 1, then reads the word at the new pointer. `rd_data` becomes {16'h0, word}, and `done` is seen two cycles after acceptance.
- R5: Op code 3 (32-bit pop) first lowers the pointer by 2. It then reads the even word and the odd word of the aligned pair, in that order. `rd_data` becomes {odd word, even word}, and `done` is seen three cycles after acceptance.
- R6: The pointer keeps odd values after 32-bit operations. Only the bus address is aligned: the first beat of a 32-bit transfer has bit 0 clear, and the second beat is the same pair with bit 0 set.
- R7: Every pointer update wraps modulo 0x10000. For example, 0xFFFE+3 gives 0x0001, and 0x0002-4 gives 0xFFFE.
- R8: Op code 4 adds the sign-extended `req_imm` (8 bits) to the pointer at the accepting edge. `done` follows one cycle later, and no bus beat occurs.
- R9: Bits 31:16 of `bus_addr` are zero on every beat.
- R10: A request presented while `busy` is high is ignored, and so are op codes 5 to 7. Neither moves the pointer, starts a beat or raises `done`.
- R11: `busy` is high exactly during bus beats and never together with `done`. `done` is a single-cycle pulse for each accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, accepted when `busy` is low |
| req_op | input | 3 | Operation code (0..4 valid) |
| req_wdata | input | 32 | Push data; 16-bit push uses bits 15:0 |
| req_imm | input | 8 | Signed pointer offset for op code 4 |
| busy | output | 1 | A bus transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Result of the last pop |
| sp_q | output | 16 | Current stack pointer |
| bus_en | output | 1 | Bus beat active this cycle |
| bus_we | output | 1 | Beat is a write |
| bus_addr | output | 32 | Word address of the beat |
| bus_wdata | output | 16 | Write data of the beat |

## Verification
The pointer changes at the same edge that accepts a request. A pointer-add reports `done` one cycle later. A 16-bit transfer has one bus beat in the first cycle after acceptance and reports `done` in the second. A 32-bit transfer has two beats and reports `done` in the third. When the driver issues a request, it records the cycle in which `done` is due, the expected pointer, any pop result, and every bus beat with its address and data. The monitor samples on the falling edge and compares each `done` and each beat against the head of its queue, including the cycle number. An extra pulse or an extra beat therefore finds no entry in the queue and is reported, as is a late or early one.

// File: rtl/sp_pkg.sv
package sp_pkg;

  typedef enum logic [2:0] {
    OP_PUSH16 = 3'd0,
    OP_PUSH32 = 3'd1,
    OP_POP16  = 3'd2,
    OP_POP32  = 3'd3,
    OP_ADDI   = 3'd4
  } op_e;

  localparam logic [2:0] OP_LAST = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BEAT0 = 2'd1,
    ST_BEAT1 = 2'd2
  } beat_st_e;

  localparam int unsigned RESET_SP = 32'h0000_0400;

endpackage

// File: rtl/sp_ptr_arith.sv
module sp_ptr_arith
  import sp_pkg::*;
#(
  parameter int unsigned SP_W  = 16,
  parameter int unsigned IMM_W = 8
) (
  input  logic [SP_W-1:0]  sp_cur,
  input  logic [2:0]       op_raw,
  input  logic [IMM_W-1:0] imm,
  output logic             op_ok,
  output logic             is_mem,
  output logic             is_wide,
  output logic             is_write,
  output logic [SP_W-1:0]  sp_next,
  output logic [SP_W-1:0]  beat_base
);

  localparam int unsigned EXT_W = SP_W - IMM_W;

  logic [SP_W-1:0] imm_ext;
  logic [SP_W-1:0] step;
  logic [SP_W-1:0] raw_base;
  op_e             op;

  generate
    if (EXT_W > 0) begin : g_ext
      assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    end else begin : g_trunc
      assign imm_ext = imm[SP_W-1:0];
    end
  endgenerate

  always_comb begin
    op       = op_e'(op_raw);
    op_ok    = (op_raw <= OP_LAST);
    is_mem   = op_ok && (op != OP_ADDI);
    is_wide  = (op == OP_PUSH32) || (op == OP_POP32);
    is_write = (op == OP_PUSH16) || (op == OP_PUSH32);
    step     = is_wide ? SP_W'(2) : SP_W'(1);
    sp_next  = sp_cur;
    raw_base = sp_cur;
    unique case (op)
      OP_PUSH16, OP_PUSH32: begin
        sp_next  = sp_cur + step;
        raw_base = sp_cur;
      end
      OP_POP16, OP_POP32: begin
        sp_next  = sp_cur - step;
        raw_base = sp_cur - step;
      end
      OP_ADDI: begin
        sp_next  = sp_cur + imm_ext;
      end
      default: begin
        sp_next  = sp_cur;
      end
    endcase
    // A 32-bit pair always starts on the even word; the pointer keeps its own value.
    beat_base = is_wide ? {raw_base[SP_W-1:1], 1'b0} : raw_base;
  end

endmodule

// File: rtl/sp_beat_ctrl.sv
module sp_beat_ctrl
  import sp_pkg::*;
#(
  parameter int unsigned SP_W = 16,
  parameter int unsigned DW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mem_start,
  input  logic            addi_start,
  input  logic            start_wide,
  input  logic            start_write,
  input  logic [SP_W-1:0] start_addr,
  input  logic [2*DW-1:0] start_data,
  input  logic [DW-1:0]   mem_rdata,
  output logic            busy,
  output logic            done,
  output logic            beat_hi,
  output logic            bus_en,
  output logic            bus_we,
  output logic [SP_W-1:0] bus_addr,
  output logic [DW-1:0]   bus_wdata,
  output logic [2*DW-1:0] rd_data
);

  beat_st_e        st_q, st_d;
  logic [SP_W-1:0] addr_q, addr_d;
  logic [2*DW-1:0] data_q, data_d;
  logic [2*DW-1:0] rdat_q, rdat_d;
  logic            wide_q, wide_d;
  logic            wr_q, wr_d;
  logic            done_q, done_d;
  logic            cmd_en;

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    data_d = data_q;
    rdat_d = rdat_q;
    wide_d = wide_q;
    wr_d   = wr_q;
    done_d = addi_start;
    cmd_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (mem_start) begin
          cmd_en = 1'b1;
          st_d   = ST_BEAT0;
          addr_d = start_addr;
          data_d = start_data;
          wide_d = start_wide;
          wr_d   = start_write;
        end
      end
      ST_BEAT0: begin
        if (!wr_q) begin
          rdat_d[DW-1:0] = mem_rdata;
          if (!wide_q) rdat_d[2*DW-1:DW] = '0;
        end
        if (wide_q) begin
          st_d   = ST_BEAT1;
          addr_d = {addr_q[SP_W-1:1], 1'b1};
        end else begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      ST_BEAT1: begin
        if (!wr_q) rdat_d[2*DW-1:DW] = mem_rdata;
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      rdat_q <= '0;
      addr_q <= '0;
      data_q <= '0;
      wide_q <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      rdat_q <= rdat_d;
      addr_q <= addr_d;
      if (cmd_en) begin
        data_q <= data_d;
        wide_q <= wide_d;
        wr_q   <= wr_d;
      end
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign beat_hi   = (st_q == ST_BEAT1);
  assign bus_en    = busy;
  assign bus_we    = busy && wr_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = beat_hi ? data_q[2*DW-1:DW] : data_q[DW-1:0];
  assign rd_data   = rdat_q;

endmodule

// File: rtl/sp_ram_model.sv
module sp_ram_model #(
  parameter int unsigned AW     = 16,
  parameter int unsigned DW     = 16,
  parameter int unsigned IDX_W  = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DW-1:0]    mem [DEPTH];
  logic [IDX_W-1:0] idx;
  logic             wr_en;

  assign idx   = addr[IDX_W-1:0];
  assign wr_en = en && we;

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];

  logic unused_hi;
  assign unused_hi = ^addr[AW-1:IDX_W];

endmodule

// File: rtl/sp_stack_unit.sv
module sp_stack_unit
  import sp_pkg::*;
#(
  parameter int unsigned SP_W   = 16,
  parameter int unsigned DW     = 16,
  parameter int unsigned IMM_W  = 8,
  parameter int unsigned BUS_AW = 32,
  parameter int unsigned RAM_IW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [2*DW-1:0]   req_wdata,
  input  logic [IMM_W-1:0]  req_imm,
  output logic              busy,
  output logic              done,
  output logic [2*DW-1:0]   rd_data,
  output logic [SP_W-1:0]   sp_q,
  output logic              bus_en,
  output logic              bus_we,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [DW-1:0]     bus_wdata
);

  localparam int unsigned PAD_W = BUS_AW - SP_W;

  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic [SP_W-1:0] sp_d;
  logic            sp_en;
  logic            accept;
  logic            op_ok, is_mem, is_wide, is_write;
  logic [SP_W-1:0] sp_calc;
  logic [SP_W-1:0] base_addr;
  logic [SP_W-1:0] beat_addr;
  logic [DW-1:0]   ram_rdata;
  logic            beat_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sp_ptr_arith #(.SP_W(SP_W), .IMM_W(IMM_W)) arith_i (
    .sp_cur   (sp_q),
    .op_raw   (req_op),
    .imm      (req_imm),
    .op_ok    (op_ok),
    .is_mem   (is_mem),
    .is_wide  (is_wide),
    .is_write (is_write),
    .sp_next  (sp_calc),
    .beat_base(base_addr)
  );

  always_comb begin
    accept = req_valid && !busy && op_ok;
    sp_en  = accept;
    sp_d   = sp_calc;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  sp_q <= SP_W'(RESET_SP);
    else if (sp_en)  sp_q <= sp_d;
  end

  sp_beat_ctrl #(.SP_W(SP_W), .DW(DW)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .mem_start  (accept && is_mem),
    .addi_start (accept && !is_mem),
    .start_wide (is_wide),
    .start_write(is_write),
    .start_addr (base_addr),
    .start_data (req_wdata),
    .mem_rdata  (ram_rdata),
    .busy       (busy),
    .done       (done),
    .beat_hi    (beat_hi),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (beat_addr),
    .bus_wdata  (bus_wdata),
    .rd_data    (rd_data)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign bus_addr = {{PAD_W{1'b0}}, beat_addr};
    end else begin : g_nopad
      assign bus_addr = beat_addr[BUS_AW-1:0];
    end
  endgenerate

  sp_ram_model #(.AW(SP_W), .DW(DW), .IDX_W(RAM_IW)) ram_i (
    .clk  (clk),
    .en   (bus_en),
    .we   (bus_we),
    .addr (beat_addr),
    .wdata(bus_wdata),
    .rdata(ram_rdata)
  );

endmodule

// File: rtl/sp_stack_unit_chk.sv
module sp_stack_unit_chk #(
  parameter int unsigned SP_W   = 16,
  parameter int unsigned IMM_W  = 8,
  parameter int unsigned BUS_AW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [2:0]        req_op,
  input logic [IMM_W-1:0]  req_imm,
  input logic              busy,
  input logic              done,
  input logic              bus_en,
  input logic              beat_hi,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [SP_W-1:0]   sp_q
);

  logic [SP_W-1:0] imm_wide;
  logic            addi_acc;
  assign imm_wide = SP_W'($signed(req_imm));
  assign addi_acc = req_valid && !busy && (req_op == 3'd4);

  // R11: completion never overlaps a transfer
  a_r11_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R11: the end of a transfer is reported at once
  a_r11_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R8: pointer add finishes next cycle with no beat
  a_r8_addi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    addi_acc |=> (done && !bus_en));

  // R7: pointer add wraps modulo 2^16
  a_r7_addi_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    addi_acc |=> (sp_q == SP_W'($past(sp_q) + $past(imm_wide))));

  // R6: second beat is the odd word of the same pair
  a_r6_pair_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && beat_hi) |-> (bus_addr[0] && bus_addr[SP_W-1:1] == $past(bus_addr[SP_W-1:1])));

  // R6: first beat of a pair is the even word
  a_r6_pair_lower: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && beat_hi) |-> $past(bus_en && !beat_hi && !bus_addr[0]));

  // R10: the pointer holds while a transfer runs
  a_r10_sp_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(sp_q));

endmodule

bind sp_stack_unit sp_stack_unit_chk #(.SP_W(SP_W), .IMM_W(IMM_W), .BUS_AW(BUS_AW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_op   (req_op),
  .req_imm  (req_imm),
  .busy     (busy),
  .done     (done),
  .bus_en   (bus_en),
  .beat_hi  (beat_hi),
  .bus_addr (bus_addr),
  .sp_q     (sp_q)
);

// File: tb/sp_stack_unit_tb_top.sv
module sp_stack_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;
  localparam int RAM_MASK   = 255;

  typedef struct {
    logic [15:0] sp;
    logic        chk_rd;
    logic [31:0] rd;
    int          due;
    string       tag;
  } done_item_t;

  typedef struct {
    logic        we;
    logic [15:0] addr;
    logic [15:0] data;
    string       tag;
  } beat_item_t;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_op;
  logic [31:0] req_wdata;
  logic [7:0]  req_imm;
  logic        busy;
  logic        done;
  logic [31:0] rd_data;
  logic [15:0] sp_q;
  logic        bus_en;
  logic        bus_we;
  logic [31:0] bus_addr;
  logic [15:0] bus_wdata;

  int checks;
  int errors;
  int cyc;
  bit mon_on;
  bit finished;

  done_item_t  dq[$];
  beat_item_t  bq[$];
  logic [15:0] mdl_mem [int];
  logic [15:0] mdl_sp;

  sp_stack_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_wdata(req_wdata), .req_imm(req_imm), .busy(busy), .done(done),
    .rd_data(rd_data), .sp_q(sp_q), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Monitor: compare completions and bus beats with the scoreboard queues
  always @(negedge clk) begin
    if (mon_on) begin
      if (done) begin
        if (dq.size() == 0) begin
          check(1'b0, "R10/R11", "unexpected done", 32'(sp_q), 32'hx);
        end else begin
          done_item_t it;
          it = dq.pop_front();
          check(sp_q === it.sp, it.tag, "pointer", 32'(sp_q), 32'(it.sp));
          check(cyc == it.due, "R11", {it.tag, " done cycle"}, 32'(cyc), 32'(it.due));
          if (it.chk_rd) check(rd_data === it.rd, it.tag, "rd_data", rd_data, it.rd);
        end
      end
      if (bus_en) begin
        check(bus_addr[31:16] === 16'h0, "R9", "upper address bits", bus_addr, 32'h0);
        check(busy === 1'b1, "R11", "busy during beat", 32'(busy), 32'h1);
        if (bq.size() == 0) begin
          check(1'b0, "R8/R10", "unexpected beat", bus_addr, 32'hx);
        end else begin
          beat_item_t b;
          b = bq.pop_front();
          check(bus_we === b.we, b.tag, "beat direction", 32'(bus_we), 32'(b.we));
          check(bus_addr[15:0] === b.addr, b.tag, "beat address", bus_addr, 32'(b.addr));
          if (b.we) check(bus_wdata === b.data, b.tag, "beat data", 32'(bus_wdata), 32'(b.data));
        end
      end
    end
  end

  function automatic int midx(input logic [15:0] a);
    return int'(a) & RAM_MASK;
  endfunction

  task automatic add_beat(input logic we, input logic [15:0] a, input logic [15:0] d,
                          input string tag);
    beat_item_t b;
    b.we = we; b.addr = a; b.data = d; b.tag = tag;
    bq.push_back(b);
    if (we) mdl_mem[midx(a)] = d;
  endtask

  // Driver: computes expected results, queues them, then presents the request
  task automatic issue(input logic [2:0] op, input logic [31:0] wd, input logic [7:0] imm,
                       input string tag);
    done_item_t it;
    logic [15:0] a;
    int lat;
    while (busy) @(negedge clk);
    it.chk_rd = 1'b0;
    it.rd     = '0;
    case (op)
      3'd0: begin
        add_beat(1'b1, mdl_sp, wd[15:0], tag);
        mdl_sp = mdl_sp + 16'd1; lat = 2;
      end
      3'd1: begin
        a = {mdl_sp[15:1], 1'b0};
        add_beat(1'b1, a, wd[15:0], tag);
        add_beat(1'b1, a | 16'd1, wd[31:16], tag);
        mdl_sp = mdl_sp + 16'd2; lat = 3;
      end
      3'd2: begin
        mdl_sp = mdl_sp - 16'd1;
        add_beat(1'b0, mdl_sp, 16'h0, tag);
        it.chk_rd = 1'b1; it.rd = {16'h0, mdl_mem[midx(mdl_sp)]}; lat = 2;
      end
      3'd3: begin
        mdl_sp = mdl_sp - 16'd2;
        a = {mdl_sp[15:1], 1'b0};
        add_beat(1'b0, a, 16'h0, tag);
        add_beat(1'b0, a | 16'd1, 16'h0, tag);
        it.chk_rd = 1'b1; it.rd = {mdl_mem[midx(a | 16'd1)], mdl_mem[midx(a)]}; lat = 3;
      end
      default: begin
        mdl_sp = mdl_sp + {{8{imm[7]}}, imm}; lat = 1;
      end
    endcase
    it.sp  = mdl_sp;
    it.due = cyc + lat;
    it.tag = tag;
    dq.push_back(it);
    req_valid = 1'b1; req_op = op; req_wdata = wd; req_imm = imm;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    while (busy || dq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected fewer cycles", WATCHDOG);
    finish_run();
  end

  initial begin
    checks = 0; errors = 0; cyc = 0; mon_on = 0; finished = 0;
    req_valid = 0; req_op = 0; req_wdata = 0; req_imm = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(sp_q === 16'h0400, "R1", "reset pointer", 32'(sp_q), 32'h400);
    check(busy === 1'b0, "R1", "reset busy", 32'(busy), 32'h0);
    check(done === 1'b0, "R1", "reset done", 32'(done), 32'h0);
    check(bus_en === 1'b0, "R1", "reset bus_en", 32'(bus_en), 32'h0);
    mdl_sp = 16'h0400;
    mon_on = 1'b1;

    issue(3'd0, 32'h0000_1111, 8'h00, "R2");
    issue(3'd1, 32'hAAAA_BBBB, 8'h00, "R3");   // pointer 0x0401: pair 0x0400/0x0401
    settle();
    check(sp_q === 16'h0403, "R6", "odd pointer kept after 32-bit push", 32'(sp_q), 32'h403);
    issue(3'd0, 32'h0000_2222, 8'h00, "R2");
    issue(3'd2, 32'h0, 8'h00, "R4");
    issue(3'd3, 32'h0, 8'h00, "R5");            // 0x0403 -> 0x0401, pair 0x0400
    settle();
    check(sp_q === 16'h0401, "R6", "odd pointer kept after 32-bit pop", 32'(sp_q), 32'h401);

    // R8: back-to-back signed adds
    issue(3'd4, 32'h0, 8'hFF, "R8");
    issue(3'd4, 32'h0, 8'h7F, "R8");
    issue(3'd4, 32'h0, 8'h80, "R8");
    issue(3'd1, 32'h1234_5678, 8'h00, "R3");    // at 0x03FF: pair 0x03FE/0x03FF
    issue(3'd2, 32'h0, 8'h00, "R4");
    settle();

    // R10: requests during a transfer are dropped
    issue(3'd1, 32'hCAFE_F00D, 8'h00, "R3");
    check(busy === 1'b1, "R11", "busy after 32-bit accept", 32'(busy), 32'h1);
    req_valid = 1'b1; req_op = 3'd4; req_imm = 8'h05;
    @(posedge clk); @(negedge clk);
    check(busy === 1'b1, "R10", "still busy during ignored request", 32'(busy), 32'h1);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    settle();
    check(sp_q === mdl_sp, "R10", "pointer after request while busy", 32'(sp_q), 32'(mdl_sp));

    // R10: reserved op codes
    for (int k = 5; k < 8; k++) begin
      req_valid = 1'b1; req_op = 3'(k); req_imm = 8'h10; req_wdata = 32'hDEAD_BEEF;
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0;
      check(sp_q === mdl_sp && bus_en === 1'b0, "R10", "reserved op moved pointer",
            32'(sp_q), 32'(mdl_sp));
    end
    repeat (3) @(negedge clk);

    // R7: walk down to 0xFFFE by wrapping below zero
    while (mdl_sp != 16'hFFFE) begin
      int diff;
      diff = int'(mdl_sp) - 32'hFFFE;
      if (diff > 0) diff = diff - 32'h10000;
      diff = -diff;
      if (diff > 128) issue(3'd4, 32'h0, 8'h80, "R7");
      else issue(3'd4, 32'h0, 8'(-diff), "R7");
    end
    settle();
    check(sp_q === 16'hFFFE, "R7", "wrap below zero", 32'(sp_q), 32'hFFFE);
    issue(3'd4, 32'h0, 8'h03, "R7");
    settle();
    check(sp_q === 16'h0001, "R7", "0xFFFE+3", 32'(sp_q), 32'h1);
    issue(3'd4, 32'h0, 8'h01, "R7");
    issue(3'd4, 32'h0, 8'hFC, "R7");
    settle();
    check(sp_q === 16'hFFFE, "R7", "0x0002-4", 32'(sp_q), 32'hFFFE);

    issue(3'd1, 32'h5A5A_A5A5, 8'h00, "R7");    // wraps to 0x0000
    issue(3'd0, 32'h0000_7E7E, 8'h00, "R7");
    issue(3'd2, 32'h0, 8'h00, "R7");
    issue(3'd3, 32'h0, 8'h00, "R7");            // wraps back to 0xFFFE
    issue(3'd4, 32'h0, 8'h01, "R7");
    issue(3'd0, 32'h0000_0F0F, 8'h00, "R7");    // 0xFFFF -> 0x0000
    issue(3'd3, 32'h0, 8'h00, "R5");            // 0xFFFE pair
    settle();
    check(sp_q === 16'hFFFE, "R7", "final pointer", 32'(sp_q), 32'hFFFE);

    repeat (4) @(negedge clk);
    check(dq.size() == 0, "R11", "pending completions", 32'(dq.size()), 32'h0);
    check(bq.size() == 0, "R2", "pending beats", 32'(bq.size()), 32'h0);
    finish_run();
  end

endmodule